// File: doc/BRIEF.md
# Dual Four-Bit Addressable Latch

This block keeps two banks of four output bits that share one set of controls: a two-bit select, an active-low write enable and an active-low functional clear. Each bank has its own serial data input. The enable and clear pins together choose one of four modes. Clear zeroes every output. Demultiplex steers each bank's data to the selected bit and zeroes the other three. Latch writes each bank's data into the selected bit and leaves the other bits unchanged. Hold keeps every bit unchanged. Software or a sequencer uses it as a serial-to-parallel converter or as randomly addressed single-bit storage.

All state is held in flip-flops. The inputs are sampled on the rising clock edge, and each mode's result appears on the outputs one cycle later. In the latch mode, a select that jumps by more than one bit could pass through a wrong address in a real system. A monitor therefore raises a sticky warning when that happens. A separate input clears the warning.

Top module: `dual_addr_latch`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, all eight outputs and `warn` are low on the next cycle.
- R2: With `en_n`=1 and `clr_n`=0 (clear mode), all eight outputs are low one cycle later, whatever `sel` and `din` are.
- R3: With `en_n`=0 and `clr_n`=0 (demultiplex mode), output bit `sel` of each bank equals that bank's data one cycle later, and the other three bits of that bank are low.
- R4: With `en_n`=0 and `clr_n`=1 (latch mode), output bit `sel` of each bank takes that bank's data one cycle later, and the other three bits keep their values.
- R5: With `en_n`=1 and `clr_n`=1 (hold mode), every output keeps its value, whatever `sel` and `din` are.
- R6: Both banks use the same `sel`. Bank 0 takes `din[0]` and drives `q[3:0]`. Bank 1 takes `din[1]` and drives `q[7:4]`. A select value k addresses bit k of each bank, which is `q[k]` and `q[4+k]`.
- R7: Every mode's effect appears exactly one clock edge after its inputs are sampled, never at the sampling edge itself.
- R8: `warn` goes high one cycle after an edge at which three conditions hold: the latch mode is sampled, `sel` differs from the `sel` sampled at the previous edge in two or more bits, and that previous edge was not a reset edge. A one-bit change, or a change in any other mode, does not raise it.
- R9: `warn` stays high until `warn_clr` is sampled high, which lowers it one cycle later. If a new R8 event and `warn_clr` arrive at the same edge, the event wins and `warn` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en_n | input | 1 | Active-low write enable |
| clr_n | input | 1 | Active-low functional clear |
| sel | input | 2 | Shared bit select |
| din | input | 2 | Data, one bit per bank |
| warn_clr | input | 1 | Clears the sticky select warning |
| q | output | 8 | Outputs, bank 1 in [7:4], bank 0 in [3:0] |
| warn | output | 1 | Sticky multi-bit select change warning |

## Verification
The warning monitor's set path and its clear path can fall on the same edge. This happens when a latch-mode select jump by two bits coincides with `warn_clr` high. The bench provokes it with a directed sequence and with pseudo-random sweeps that drive `warn_clr` while select jumps occur. A reference model computed in the bench judges the result: the warning must stay high. The same sweeps also hit latch-mode writes together with select jumps. There, the data bits must still follow R4 while the flag rises.

// File: rtl/dal_pkg.sv
package dal_pkg;

  typedef enum logic [1:0] {
    MODE_CLEAR = 2'd0,
    MODE_DEMUX = 2'd1,
    MODE_LATCH = 2'd2,
    MODE_HOLD  = 2'd3
  } mode_e;

  // Control pair to mode: clear active wins the zeroing, enable picks steering.
  function automatic mode_e decode_mode(input logic en_n, input logic clr_n);
    case ({en_n, clr_n})
      2'b10:   return MODE_CLEAR;
      2'b00:   return MODE_DEMUX;
      2'b01:   return MODE_LATCH;
      default: return MODE_HOLD;
    endcase
  endfunction

endpackage

// File: rtl/dal_mode_decode.sv
module dal_mode_decode
  import dal_pkg::*;
(
  input  logic  en_n,
  input  logic  clr_n,
  output mode_e mode,
  output logic  is_clear,
  output logic  is_demux,
  output logic  is_latch,
  output logic  is_hold
);
  assign mode     = decode_mode(en_n, clr_n);
  assign is_clear = (mode == MODE_CLEAR);
  assign is_demux = (mode == MODE_DEMUX);
  assign is_latch = (mode == MODE_LATCH);
  assign is_hold  = (mode == MODE_HOLD);

  always_comb begin
    assert ($onehot({is_clear, is_demux, is_latch, is_hold}))
      else $error("p_mode_onehot_r2: mode flags not one-hot");
  end
endmodule

// File: rtl/dal_channel.sv
module dal_channel
  import dal_pkg::*;
#(
  parameter  int ADDR_W = 2,
  localparam int BITS   = 1 << ADDR_W
) (
  input  logic            clk,
  input  logic            rst,
  input  mode_e           mode,
  input  logic [BITS-1:0] sel_hot,
  input  logic            din,
  output logic [BITS-1:0] q
);
  logic [BITS-1:0] wr_mask;
  logic [BITS-1:0] keep_mask;
  logic [BITS-1:0] q_next;

  assign wr_mask   = din ? sel_hot : '0;
  assign keep_mask = ~sel_hot;

  always_comb begin
    case (mode)
      MODE_CLEAR: q_next = '0;
      MODE_DEMUX: q_next = wr_mask;
      MODE_LATCH: q_next = (q & keep_mask) | wr_mask;
      default:    q_next = q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  p_clear_mode_r2: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_CLEAR) |=> (q == '0));
  p_demux_single_r3: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_DEMUX) |=> ((q & ~$past(sel_hot)) == '0));
  p_latch_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH) |=> (((q ^ $past(q)) & $past(keep_mask)) == '0));
  p_latch_write_r4: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_LATCH) |=> ((q & $past(sel_hot)) == ($past(din) ? $past(sel_hot) : '0)));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mode == MODE_HOLD) |=> $stable(q));
endmodule

// File: rtl/dal_sel_monitor.sv
module dal_sel_monitor
  import dal_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  mode_e             mode,
  input  logic [ADDR_W-1:0] sel,
  input  logic              warn_clr,
  output logic              glitch_evt,
  output logic              warn
);
  logic [ADDR_W-1:0] sel_prev;
  logic              prev_ok;
  logic [ADDR_W:0]   flips;

  function automatic logic [ADDR_W:0] count_flips(input logic [ADDR_W-1:0] a,
                                                  input logic [ADDR_W-1:0] b);
    logic [ADDR_W:0] n;
    n = '0;
    for (int i = 0; i < ADDR_W; i++) n = n + {{ADDR_W{1'b0}}, a[i] ^ b[i]};
    return n;
  endfunction

  assign flips      = count_flips(sel, sel_prev);
  assign glitch_evt = prev_ok && (mode == MODE_LATCH) && (flips > 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_prev <= '0;
      prev_ok  <= 1'b0;
      warn     <= 1'b0;
    end else begin
      sel_prev <= sel;
      prev_ok  <= 1'b1;
      if (glitch_evt)    warn <= 1'b1;
      else if (warn_clr) warn <= 1'b0;
    end
  end

  p_glitch_sets_r8: assert property (@(posedge clk) disable iff (rst)
    glitch_evt |=> warn);
  p_no_spurious_r8: assert property (@(posedge clk) disable iff (rst)
    (!warn && !glitch_evt) |=> !warn);
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (warn && !warn_clr) |=> warn);
  p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (warn_clr && !glitch_evt) |=> !warn);
endmodule

// File: rtl/dual_addr_latch.sv
module dual_addr_latch
  import dal_pkg::*;
#(
  parameter  int NUM_CH = 2,
  parameter  int ADDR_W = 2,
  localparam int BITS   = 1 << ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_n,
  input  logic                   clr_n,
  input  logic [ADDR_W-1:0]      sel,
  input  logic [NUM_CH-1:0]      din,
  input  logic                   warn_clr,
  output logic [NUM_CH*BITS-1:0] q,
  output logic                   warn
);
  mode_e           mode;
  logic            is_clear, is_demux, is_latch, is_hold;
  logic [BITS-1:0] sel_hot;
  logic            glitch_evt;

  assign sel_hot = BITS'(1) << sel;

  dal_mode_decode u_dec (
    .en_n(en_n), .clr_n(clr_n), .mode(mode),
    .is_clear(is_clear), .is_demux(is_demux),
    .is_latch(is_latch), .is_hold(is_hold)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_bank
    dal_channel #(.ADDR_W(ADDR_W)) u_bank (
      .clk(clk), .rst(rst), .mode(mode), .sel_hot(sel_hot),
      .din(din[c]), .q(q[c*BITS +: BITS])
    );
  end

  dal_sel_monitor #(.ADDR_W(ADDR_W)) u_mon (
    .clk(clk), .rst(rst), .mode(mode), .sel(sel),
    .warn_clr(warn_clr), .glitch_evt(glitch_evt), .warn(warn)
  );

  // R1: reset leaves everything low on the following cycle
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (q == '0 && !warn));
  // R5: hold mode never disturbs the warning once no event occurs
  p_hold_no_event_r8: assert property (@(posedge clk) disable iff (rst)
    is_hold |-> !glitch_evt);
endmodule

// File: tb/tb_dual_addr_latch.sv
module tb_dual_addr_latch;
  logic       clk = 1'b0;
  logic       rst;
  logic       en_n, clr_n, warn_clr;
  logic [1:0] sel, din;
  logic [7:0] q;
  logic       warn;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [7:0] exp_q;
  logic       exp_warn;
  logic [1:0] m_prev;
  logic       m_prev_ok;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  dual_addr_latch dut (
    .clk(clk), .rst(rst), .en_n(en_n), .clr_n(clr_n), .sel(sel),
    .din(din), .warn_clr(warn_clr), .q(q), .warn(warn)
  );

  function automatic string mode_tag(input logic e, input logic c);
    if (e && !c)  return "R2 clear";
    if (!e && !c) return "R3 demux";
    if (!e && c)  return "R4 latch";
    return "R5 hold";
  endfunction

  // Reference step, written per bit with arithmetic addressing
  task automatic model_edge();
    logic [7:0] nq;
    int   flip;
    bit   ev;
    if (rst) begin
      exp_q = 0; exp_warn = 0; m_prev = 0; m_prev_ok = 0;
      return;
    end
    nq = exp_q;
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < 4; k++) begin
        int idx = b * 4 + k;
        bit hit = (k == int'(sel));
        if (en_n && !clr_n)       nq[idx] = 1'b0;
        else if (!en_n && !clr_n) nq[idx] = hit ? din[b] : 1'b0;
        else if (!en_n && clr_n)  nq[idx] = hit ? din[b] : exp_q[idx];
      end
    flip = int'(sel[0] != m_prev[0]) + int'(sel[1] != m_prev[1]);
    ev = m_prev_ok && !en_n && clr_n && (flip >= 2);
    if (ev) exp_warn = 1'b1;
    else if (warn_clr) exp_warn = 1'b0;
    exp_q = nq;
    m_prev = sel;
    m_prev_ok = 1'b1;
  endtask

  task automatic check(input string tag);
    n_tests++;
    if (q !== exp_q) begin
      n_fail++;
      $display("FAIL %s: q=%h expected %h", tag, q, exp_q);
    end
    n_tests++;
    if (warn !== exp_warn) begin
      n_fail++;
      $display("FAIL %s (R8/R9 warn): warn=%b expected %b", tag, warn, exp_warn);
    end
  endtask

  // Apply at negedge, clock, then compare at the next negedge (R7 latency)
  task automatic step(input logic r, input logic e, input logic c,
                      input logic [1:0] s, input logic [1:0] d, input logic wc,
                      input string tag);
    rst = r; en_n = e; clr_n = c; sel = s; din = d; warn_clr = wc;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic rnd_step(input bit allow_clr);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    step(1'b0, lfsr[0], lfsr[1] | lfsr[9], lfsr[3:2], lfsr[5:4],
         allow_clr & lfsr[6] & lfsr[7], mode_tag(lfsr[0], lfsr[1] | lfsr[9]));
  endtask

  initial begin
    #(20 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    if (!done) begin
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1; en_n = 1; clr_n = 1; sel = 0; din = 0; warn_clr = 0;
    exp_q = 0; exp_warn = 0; m_prev = 0; m_prev_ok = 0;
    @(negedge clk);
    step(1, 1, 1, 2'd0, 2'd0, 0, "R1 reset");

    // R6/R4: fill each bit with distinct per-bank data, single-bit select moves
    step(0, 0, 1, 2'd0, 2'b01, 0, "R6 latch sel0");
    step(0, 0, 1, 2'd1, 2'b10, 0, "R6 latch sel1");
    step(0, 0, 1, 2'd3, 2'b11, 0, "R6 latch sel3");
    step(0, 0, 1, 2'd2, 2'b01, 0, "R6 latch sel2");
    n_tests++;
    if (q !== 8'b1010_1101) begin
      n_fail++;
      $display("FAIL R6 mapping: q=%b expected %b", q, 8'b1010_1101);
    end
    // R5: hold ignores data and select
    step(0, 1, 1, 2'd1, 2'b00, 0, "R5 hold");
    // R8: two-bit jump 1->2 in latch mode
    step(0, 0, 1, 2'd2, 2'b00, 0, "R8 jump");
    step(0, 1, 1, 2'd2, 2'b00, 0, "R9 sticky");
    step(0, 1, 1, 2'd2, 2'b00, 1, "R9 clear");
    // R9: event and clear on the same edge, event wins
    step(0, 0, 1, 2'd1, 2'b11, 1, "R9 set+clear");
    n_tests++;
    if (warn !== 1'b1) begin
      n_fail++;
      $display("FAIL R9 same-edge: warn=%b expected 1", warn);
    end
    step(0, 1, 1, 2'd1, 2'b00, 1, "R9 clear");
    // R8: jump in hold mode does not flag
    step(0, 1, 1, 2'd2, 2'b00, 0, "R8 hold jump");
    // R3 then R2
    step(0, 0, 0, 2'd3, 2'b10, 0, "R3 demux");
    step(0, 1, 0, 2'd1, 2'b11, 0, "R2 clear");
    // R1: reset in mid-run, and no flag on first edge after it
    step(0, 0, 1, 2'd0, 2'b11, 0, "R4 latch");
    step(1, 0, 1, 2'd3, 2'b11, 0, "R1 reset");
    step(0, 0, 1, 2'd3, 2'b11, 0, "R8 post-reset");

    // Exhaustive sweep: every mode, select, data, from varied prior states
    for (int pass = 0; pass < 4; pass++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 4; s++)
          for (int d = 0; d < 4; d++) begin
            step(0, m[1], m[0], s[1:0], d[1:0], 1'((pass + s) % 3 == 0),
                 mode_tag(m[1], m[0]));
            rnd_step(1'b0);
          end
    for (int i = 0; i < 3000; i++) rnd_step(1'b1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule